// File: doc/BRIEF.md
# NAND Flash Command and Address Front End

This block is the device side of a small NAND flash that has one multiplexed 8-bit bus. The host sends commands, address bytes and write data over the same lines. Two qualifiers set what each byte means: a command-latch enable and an address-latch enable. A byte is taken in on the rising edge of an active-low write strobe, and only while the active-low chip enable is asserted. The block decodes the command set and builds a 19-bit byte address over several address cycles. It keeps a 32-byte frame register, which is filled from the bus for a program and from the array for a read. Read data leaves through a column counter that moves one place on each falling edge of the read strobe.

Program, erase and the array fetch of a read each hold ready/busy low for a set number of clock cycles, given by a parameter. A status byte reports readiness, write protection and whether the last operation passed. Write-protect, sampled at the confirm command, blocks program and erase. The storage is a small synthesizable memory of 16 frames. It is indexed by the frame bits A6:A5, the lowest row bit A7 and the lowest block bit A12. All other address bits alias onto these frames.

Top module: `nand_flash_fe`

## Requirements
- R1: Bus bytes are taken only on a rising edge of `we_ni` while `ce_ni` is low. Strobes given while `ce_ni` is high start nothing, and ready/busy stays high.
- R2: A byte is a command when `cle_i`=1 and `ale_i`=0, an address byte when `ale_i`=1 and `cle_i`=0, and write data when both are 0.
- R3: The program sequence is 80h, then three address cycles, then data bytes, then 10h. It stores into the addressed frame the bitwise AND of the old contents and the frame register. On 80h the frame register is preset to FFh, and data bytes are written from the start column upward.
- R4: Read and program use three address cycles: A7..A0, then A15..A8, then A18..A16 in bits 2..0 of the third byte. Bits 7..3 of the third byte are ignored. The column is A4..A0, and the stored frame index is {A12, A7, A6, A5}. All other address bits alias.
- R5: The erase sequence is 60h, then two address cycles carrying A15..A8 and A18..A16, then D0h. It sets to FFh every stored frame whose A12 matches.
- R6: A read is 00h plus three address cycles. When the fetch is done, each falling edge of `re_ni` drives the frame byte at the column counter onto `io_o` and then adds one to the counter. The counter wraps from 31 to 0.
- R7: `rb_o` is low for exactly T_READ, T_PROG or T_ERASE clock cycles after the last address byte of a read, or after the 10h or D0h confirm. It is high out of reset.
- R8: `ce_ni` high during a read fetch or during read data output returns the block to standby: `rb_o` goes high and output is disabled. `ce_ni` high during a program or erase busy period has no effect.
- R9: When `wp_ni` is low at the 10h or D0h confirm, the operation does not start, `rb_o` stays high, the array is unchanged, and the status fail bit is set.
- R10: While busy, only FFh (reset) and 70h (status) are accepted. FFh aborts a program with no array write, and `rb_o` returns high. All other commands are ignored.
- R11: The status byte after 70h is: bit 7 = `wp_ni`, bit 6 = ready, bit 0 = fail of the last operation, bits 5..1 = 0. The fail bit is cleared when any operation completes.
- R12: After 90h, successive read strobes return 3Ch and A4h alternately, starting with 3Ch.
- R13: `io_oe_o` is high only while `ce_ni` and `re_ni` are both low and an output mode (array, status or identifier) is selected. Out of reset it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch qualifier |
| ale_i | input | 1 | Address latch qualifier |
| we_ni | input | 1 | Write strobe, active low, byte taken on rising edge |
| re_ni | input | 1 | Read strobe, active low, advances on falling edge |
| wp_ni | input | 1 | Write protect, active low |
| io_i | input | 8 | Bus input: command, address or data |
| io_o | output | 8 | Bus output data |
| io_oe_o | output | 1 | Bus output enable |
| rb_o | output | 1 | Ready (1) or busy (0) |

## Verification
The bench programs all 16 stored frames with a different arithmetic byte pattern in each frame. It then reads every byte back through addresses that have the aliased high bits and the ignored bits of the third address byte set. A wrong field position or a wrong decoding of the third byte therefore shows up as a miscompare. A block erase is followed by another full sweep, which shows whether one erase clears exactly the frames of the matching block. A partial program over data that is already written checks the AND behaviour and the starting column, and a read that begins at column 30 checks the wrap. Separate short sequences try write-protect, reset during busy, a command sent while busy, chip enable high in each phase, status read during and after busy, and the identifier bytes. Each of these yields an outcome that differs between a correct design and one that handles the case wrongly.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_LOAD, PH_CONF, PH_BUSY} phase_e;
  typedef enum logic [1:0] {OP_READ, OP_PROG, OP_ERASE} op_e;
  typedef enum logic [1:0] {OUT_NONE, OUT_ARRAY, OUT_STAT, OUT_ID} out_e;

  localparam logic [7:0] CMD_READ     = 8'h00;
  localparam logic [7:0] CMD_RESET    = 8'hFF;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_ID       = 8'h90;
endpackage

// File: rtl/nand_fe_strobe.sv
module nand_fe_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic cle_i,
  input  logic ale_i,
  input  logic we_ni,
  input  logic re_ni,
  output logic cmd_v_o,
  output logic addr_v_o,
  output logic data_v_o,
  output logic re_fall_o
);
  logic we_q, re_q, we_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_ni;
      re_q <= re_ni;
    end
  end

  assign we_rise   = !we_q && we_ni && !ce_ni;
  assign cmd_v_o   = we_rise && cle_i && !ale_i;
  assign addr_v_o  = we_rise && ale_i && !cle_i;
  assign data_v_o  = we_rise && !ale_i && !cle_i;
  assign re_fall_o = re_q && !re_ni && !ce_ni;
endmodule

// File: rtl/nand_fe_array.sv
module nand_fe_array #(
  parameter int FRAME_BYTES = 32,
  parameter int IDX_W       = 4,
  parameter int BLK_BITS    = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     prog_i,
  input  logic                     erase_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [BLK_BITS-1:0]      blk_i,
  input  logic [FRAME_BYTES*8-1:0] wdata_i,
  output logic [FRAME_BYTES*8-1:0] rdata_o
);
  localparam int FRAMES = 1 << IDX_W;
  localparam int FW     = FRAME_BYTES * 8;

  logic [FW-1:0] mem_q [FRAMES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int f = 0; f < FRAMES; f++) mem_q[f] <= '1;
    end else if (erase_i) begin
      for (int f = 0; f < FRAMES; f++)
        if ((f >> (IDX_W - BLK_BITS)) == int'(blk_i)) mem_q[f] <= '1;
    end else if (prog_i) begin
      // cells only move from 1 to 0 when programmed
      mem_q[idx_i] <= mem_q[idx_i] & wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/nand_flash_fe.sv
module nand_flash_fe
  import nand_fe_pkg::*;
#(
  parameter int         FRAME_BYTES = 32,
  parameter int         BLK_BITS    = 1,
  parameter int         ROW_BITS    = 1,
  parameter int         T_READ      = 4,
  parameter int         T_PROG      = 16,
  parameter int         T_ERASE     = 24,
  parameter logic [7:0] ID_MAKER    = 8'h3C,
  parameter logic [7:0] ID_DEV      = 8'hA4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_ni,
  input  logic       re_ni,
  input  logic       wp_ni,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  output logic       rb_o
);
  localparam int ADDR_W  = 19;
  localparam int COL_W   = $clog2(FRAME_BYTES);
  localparam int FRM_LSB = COL_W;
  localparam int ROW_LSB = COL_W + 2;
  localparam int BLK_LSB = ROW_LSB + 5;
  localparam int IDX_W   = BLK_BITS + ROW_BITS + 2;
  localparam int T_MAX   = (T_READ > T_PROG) ? ((T_READ > T_ERASE) ? T_READ : T_ERASE)
                                             : ((T_PROG > T_ERASE) ? T_PROG : T_ERASE);
  localparam int CNT_W   = $clog2(T_MAX + 1);

  logic cmd_v, addr_v, data_v, re_fall;
  phase_e            phase_q;
  op_e               op_q;
  out_e              out_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        acnt_q, abyte;
  logic [COL_W-1:0]  col_q;
  logic [7:0]        frame_q [FRAME_BYTES];
  logic [CNT_W-1:0]  cnt_q;
  logic              fail_q, id_sel_q;
  logic [7:0]        dout_q, status;
  logic              busy, done, standby;
  logic [IDX_W-1:0]  idx;
  logic [FRAME_BYTES*8-1:0] frame_flat, rdata;

  nand_fe_strobe u_strobe (
    .clk_i, .rst_ni, .ce_ni, .cle_i, .ale_i, .we_ni, .re_ni,
    .cmd_v_o(cmd_v), .addr_v_o(addr_v), .data_v_o(data_v), .re_fall_o(re_fall)
  );

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_pack
    assign frame_flat[g*8 +: 8] = frame_q[g];
  end

  assign busy    = (phase_q == PH_BUSY);
  assign done    = busy && (cnt_q == CNT_W'(1));
  assign standby = ce_ni && (op_q == OP_READ) && (busy || out_q == OUT_ARRAY);
  assign idx     = {addr_q[BLK_LSB +: BLK_BITS], addr_q[ROW_LSB +: ROW_BITS], addr_q[FRM_LSB +: 2]};
  assign abyte   = acnt_q + ((op_q == OP_ERASE) ? 2'd1 : 2'd0);
  assign status  = {wp_ni, !busy, 5'b0, fail_q};

  nand_fe_array #(.FRAME_BYTES(FRAME_BYTES), .IDX_W(IDX_W), .BLK_BITS(BLK_BITS)) u_array (
    .clk_i, .rst_ni,
    .prog_i (done && op_q == OP_PROG && !standby),
    .erase_i(done && op_q == OP_ERASE),
    .idx_i  (idx),
    .blk_i  (addr_q[BLK_LSB +: BLK_BITS]),
    .wdata_i(frame_flat),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      op_q     <= OP_READ;
      out_q    <= OUT_NONE;
      addr_q   <= '0;
      acnt_q   <= '0;
      col_q    <= '0;
      cnt_q    <= '0;
      fail_q   <= 1'b0;
      id_sel_q <= 1'b0;
      dout_q   <= '0;
      for (int i = 0; i < FRAME_BYTES; i++) frame_q[i] <= 8'hFF;
    end else begin
      if (busy) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (done) begin
          phase_q <= PH_IDLE;
          fail_q  <= 1'b0;
          if (op_q == OP_READ) begin
            for (int i = 0; i < FRAME_BYTES; i++) frame_q[i] <= rdata[i*8 +: 8];
            col_q <= addr_q[COL_W-1:0];
            out_q <= OUT_ARRAY;
          end
        end
      end
      if (standby) begin
        phase_q <= PH_IDLE;
        out_q   <= OUT_NONE;
      end else if (cmd_v) begin
        if (io_i == CMD_RESET) begin
          phase_q <= PH_IDLE;
          out_q   <= OUT_NONE;
          cnt_q   <= '0;
        end else if (io_i == CMD_STATUS) begin
          out_q <= OUT_STAT;
        end else if (!busy) begin
          case (io_i)
            CMD_READ, CMD_PROG, CMD_ERASE: begin
              op_q    <= (io_i == CMD_READ) ? OP_READ : (io_i == CMD_PROG) ? OP_PROG : OP_ERASE;
              phase_q <= PH_ADDR;
              acnt_q  <= '0;
              out_q   <= OUT_NONE;
              if (io_i == CMD_PROG)
                for (int i = 0; i < FRAME_BYTES; i++) frame_q[i] <= 8'hFF;
            end
            CMD_PROG_GO, CMD_ERASE_GO: begin
              if ((io_i == CMD_PROG_GO  && phase_q == PH_LOAD && op_q == OP_PROG) ||
                  (io_i == CMD_ERASE_GO && phase_q == PH_CONF && op_q == OP_ERASE)) begin
                if (!wp_ni) begin
                  fail_q  <= 1'b1;
                  phase_q <= PH_IDLE;
                end else begin
                  phase_q <= PH_BUSY;
                  cnt_q   <= (op_q == OP_PROG) ? CNT_W'(T_PROG) : CNT_W'(T_ERASE);
                end
              end
            end
            CMD_ID: begin
              out_q    <= OUT_ID;
              id_sel_q <= 1'b0;
              phase_q  <= PH_IDLE;
            end
            default: ;
          endcase
        end
      end else if (addr_v && phase_q == PH_ADDR) begin
        case (abyte)
          2'd0:    addr_q[7:0]   <= io_i;
          2'd1:    addr_q[15:8]  <= io_i;
          default: addr_q[18:16] <= io_i[2:0];
        endcase
        if (abyte == 2'd2) begin
          case (op_q)
            OP_READ: begin
              phase_q <= PH_BUSY;
              cnt_q   <= CNT_W'(T_READ);
            end
            OP_PROG: begin
              phase_q <= PH_LOAD;
              col_q   <= addr_q[COL_W-1:0];
            end
            default: phase_q <= PH_CONF;
          endcase
        end else begin
          acnt_q <= acnt_q + 2'd1;
        end
      end else if (data_v && phase_q == PH_LOAD) begin
        frame_q[col_q] <= io_i;
        col_q          <= col_q + COL_W'(1);
      end else if (re_fall) begin
        case (out_q)
          OUT_ARRAY: begin
            dout_q <= frame_q[col_q];
            col_q  <= col_q + COL_W'(1);
          end
          OUT_STAT: dout_q <= status;
          OUT_ID: begin
            dout_q   <= id_sel_q ? ID_DEV : ID_MAKER;
            id_sel_q <= !id_sel_q;
          end
          default: ;
        endcase
      end
    end
  end

  assign io_o    = dout_q;
  assign io_oe_o = !ce_ni && !re_ni && (out_q != OUT_NONE);
  assign rb_o    = !busy;
endmodule

// File: rtl/nand_flash_fe_chk.sv
module nand_flash_fe_chk
  import nand_fe_pkg::*;
#(
  parameter int COL_W = 5,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             re_ni,
  input logic             wp_ni,
  input logic [7:0]       io_i,
  input logic             io_oe_o,
  input logic             rb_o,
  input logic             cmd_v,
  input logic             re_fall,
  input phase_e           phase_q,
  input op_e              op_q,
  input out_e             out_q,
  input logic [COL_W-1:0] col_q,
  input logic [CNT_W-1:0] cnt_q
);
  p_oe_gate_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o |-> (!ce_ni && !re_ni));

  p_ce_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BUSY && op_q != OP_READ && cnt_q > CNT_W'(1) && ce_ni) |=> !rb_o);

  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BUSY && cnt_q > CNT_W'(1) && cmd_v && io_i != 8'hFF) |=> !rb_o);

  p_wp_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_o && cmd_v && !wp_ni && (io_i == 8'h10 || io_i == 8'hD0)) |=> rb_o);

  p_col_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_o && re_fall && !cmd_v && out_q == OUT_ARRAY) |=> col_q == COL_W'($past(col_q) + 1'b1));
endmodule

bind nand_flash_fe nand_flash_fe_chk #(.COL_W(COL_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .re_ni(re_ni), .wp_ni(wp_ni),
  .io_i(io_i), .io_oe_o(io_oe_o), .rb_o(rb_o), .cmd_v(cmd_v), .re_fall(re_fall),
  .phase_q(phase_q), .op_q(op_q), .out_q(out_q), .col_q(col_q), .cnt_q(cnt_q)
);

// File: tb/nand_flash_fe_tb.sv
module nand_flash_fe_tb_top;
  localparam int T_READ = 4, T_PROG = 16, T_ERASE = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic oe, rb;
  int vecs = 0, errs = 0;
  logic [7:0] model [16][32];

  always #2.5 clk = !clk;

  nand_flash_fe #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .we_ni(we_n), .re_ni(re_n), .wp_ni(wp_n), .io_i(io_in),
    .io_o(io_out), .io_oe_o(oe), .rb_o(rb)
  );

  function automatic logic [18:0] faddr(input int f);
    return 19'(((f >> 3) & 1) << 12 | ((f >> 2) & 1) << 7 | (f & 3) << 5);
  endfunction

  function automatic logic [7:0] pat(input int f, input int c);
    return 8'((f * 37 + c * 11 + 5) % 256);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    cle = c; ale = a; io_in = b; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v, output logic o);
    re_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    v = io_out; o = oe;
    re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rb && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic addr3(input logic [18:0] a, input logic [4:0] junk);
    wr(1'b0, 1'b1, a[7:0]);
    wr(1'b0, 1'b1, a[15:8]);
    wr(1'b0, 1'b1, {junk, a[18:16]});
  endtask

  task automatic program_frame(input int f, input int col0, input int nbytes, input logic [7:0] fill, input bit use_pat);
    int n;
    wr(1'b1, 1'b0, 8'h80);
    addr3(faddr(f) | 19'(col0), 5'd0);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b;
      b = use_pat ? pat(f, col0 + i) : fill;
      wr(1'b0, 1'b0, b);
      model[f][(col0 + i) % 32] &= b;
    end
    wr(1'b1, 1'b0, 8'h10);
    wait_rdy(n);
    chk("R7 program busy cycles", n, T_PROG);
  endtask

  task automatic read_frame(input int f);
    int n;
    logic [7:0] v;
    logic o;
    wr(1'b1, 1'b0, 8'h00);
    addr3(faddr(f) | 19'h46000, 5'h1F);  // aliased high bits and ignored bits set
    wait_rdy(n);
    chk("R7 read busy cycles", n, T_READ);
    for (int c = 0; c < 32; c++) begin
      rd(v, o);
      chk("R4 R6 read data", v, model[f][c]);
      chk("R13 oe during read", o, 1);
    end
  endtask

  task automatic run();
    int n;
    logic [7:0] v;
    logic o;
    for (int f = 0; f < 16; f++)
      for (int c = 0; c < 32; c++) model[f][c] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R7 rb after reset", rb, 1);
    chk("R13 oe after reset", oe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R2: program every frame with its own pattern
    for (int f = 0; f < 16; f++) program_frame(f, 0, 32, 8'h00, 1'b1);
    for (int f = 0; f < 16; f++) read_frame(f);

    // R5: erase block with A12=1
    wr(1'b1, 1'b0, 8'h60);
    wr(1'b0, 1'b1, 8'h10);
    wr(1'b0, 1'b1, 8'h00);
    wr(1'b1, 1'b0, 8'hD0);
    wait_rdy(n);
    chk("R5 R7 erase busy cycles", n, T_ERASE);
    for (int f = 8; f < 16; f++)
      for (int c = 0; c < 32; c++) model[f][c] = 8'hFF;
    for (int f = 0; f < 16; f++) read_frame(f);

    // R3: partial program over written data ANDs in
    wr(1'b1, 1'b0, 8'h80);
    addr3(faddr(3) | 19'd5, 5'd0);
    wr(1'b0, 1'b0, 8'h0F); model[3][5] &= 8'h0F;
    wr(1'b0, 1'b0, 8'hF0); model[3][6] &= 8'hF0;
    wr(1'b0, 1'b0, 8'h3C); model[3][7] &= 8'h3C;
    wr(1'b1, 1'b0, 8'h10);
    wait_rdy(n);
    read_frame(3);

    // R6: wrap of column counter from 31 to 0
    wr(1'b1, 1'b0, 8'h00);
    addr3(faddr(3) | 19'd30, 5'd0);
    wait_rdy(n);
    for (int i = 0; i < 4; i++) begin
      rd(v, o);
      chk("R6 column wrap", v, model[3][(30 + i) % 32]);
    end

    // R9: write protect blocks program
    wp_n = 1'b0;
    wr(1'b1, 1'b0, 8'h80);
    addr3(faddr(8), 5'd0);
    wr(1'b0, 1'b0, 8'h00);
    wr(1'b1, 1'b0, 8'h10);
    wait_rdy(n);
    chk("R9 no busy when protected", n, 0);
    wr(1'b1, 1'b0, 8'h70);
    rd(v, o);
    chk("R9 R11 status protected fail", v, 8'h41);
    wp_n = 1'b1;
    read_frame(8);

    // R11 R10: status during busy, command ignored during busy
    wr(1'b1, 1'b0, 8'h80);
    addr3(faddr(9), 5'd0);
    for (int c = 0; c < 32; c++) begin
      wr(1'b0, 1'b0, pat(9, c));
      model[9][c] &= pat(9, c);
    end
    wr(1'b1, 1'b0, 8'h10);
    wr(1'b1, 1'b0, 8'h70);
    rd(v, o);
    chk("R11 status while busy", v, 8'h80);
    wr(1'b1, 1'b0, 8'h00);
    chk("R10 read cmd ignored while busy", rb, 0);
    wait_rdy(n);
    rd(v, o);
    chk("R11 status ready pass", v, 8'hC0);
    read_frame(9);

    // R10: reset aborts program, no array write
    wr(1'b1, 1'b0, 8'h80);
    addr3(faddr(10), 5'd0);
    wr(1'b0, 1'b0, 8'h00);
    wr(1'b0, 1'b0, 8'h00);
    wr(1'b1, 1'b0, 8'h10);
    wr(1'b1, 1'b0, 8'hFF);
    chk("R10 reset aborts busy", rb, 1);
    read_frame(10);

    // R8: chip enable high in read output returns to standby
    read_frame(0);
    ce_n = 1'b1;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b0;
    rd(v, o);
    chk("R8 standby disables output", o, 0);
    // R8: chip enable high during read fetch
    wr(1'b1, 1'b0, 8'h00);
    addr3(faddr(1), 5'd0);
    ce_n = 1'b1;
    @(negedge clk);
    chk("R8 standby ends read busy", rb, 1);
    ce_n = 1'b0;
    // R8: chip enable high ignored during program
    wr(1'b1, 1'b0, 8'h80);
    addr3(faddr(11), 5'd0);
    for (int c = 0; c < 32; c++) begin
      wr(1'b0, 1'b0, 8'h5A);
      model[11][c] &= 8'h5A;
    end
    wr(1'b1, 1'b0, 8'h10);
    ce_n = 1'b1;
    wait_rdy(n);
    ce_n = 1'b0;
    chk("R8 program busy unaffected by ce", n, T_PROG);
    read_frame(11);

    // R1: strobes with chip enable high do nothing
    ce_n = 1'b1;
    wr(1'b1, 1'b0, 8'h60);
    wr(1'b0, 1'b1, 8'h00);
    wr(1'b0, 1'b1, 8'h00);
    wr(1'b1, 1'b0, 8'hD0);
    chk("R1 no erase started", rb, 1);
    ce_n = 1'b0;
    read_frame(0);

    // R12: identifier bytes alternate
    wr(1'b1, 1'b0, 8'h90);
    rd(v, o); chk("R12 id byte 0", v, 8'h3C);
    rd(v, o); chk("R12 id byte 1", v, 8'hA4);
    rd(v, o); chk("R12 id byte 0 again", v, 8'h3C);

    for (int f = 0; f < 16; f++) read_frame(f);
  endtask

  initial begin
    bit timeout = 1'b0;
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    if (timeout) begin
      vecs++;
      errs++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule